// File: doc/BRIEF.md
# Sign-Compressed Bisected Cache Line Data Store

This block holds the data part of one cache line of eight 32-bit words. When a block is filled, each word is checked: if its upper half-word is all zeros or all ones, only the lower half-word and one sign bit are kept. A word that fails this test is kept at full width, and a per-word status bit records which form each word takes. The physical line is built from two half-word arrays, a lower half and an upper half. A block whose eight words all shrink needs only one of these halves. Two such blocks that map to the same set can therefore share the line, and each half has its own tag.

A read gives a tag and a word index. One cycle later the block returns the rebuilt word, a hit flag, the tag slot that matched, and a two-bit enable that shows which half of the data storage took part in the access. A compressed block touches only one half. A full-width block touches both. Set indexing, victim choice across lines and the surrounding cache controller live outside this block.

Top module: `scl_line`

## Requirements
- R1: After reset neither tag slot is valid. Every read misses, with `rd_hit`=0, `rd_way`=0, `rd_half_en`=2'b00 and `rd_data`=0.
- R2: A word whose bits 31:16 are all 0 is kept as sign 0 plus bits 15:0. A word whose bits 31:16 are all 1 is kept as sign 1 plus bits 15:0. On a read it comes back as 16 copies of the sign bit above the stored low half. Example: 32'h0000_8000 comes back unchanged.
- R3: If any word of a block fails the R2 test, the block fills the whole line. Compressed and full-width words may sit side by side. Every word reads back exactly as written, with `rd_half_en`=2'b11 and `rd_way`=0.
- R4: A block whose eight words all pass the R2 test takes one half only. A hit on the lower half (tag slot 0) gives `rd_half_en`=2'b01. A hit on the upper half (tag slot 1) gives 2'b10.
- R5: A second compressible block with a new tag goes into the free half. Both blocks then hit on their own tags, and at most one tag slot matches any request.
- R6: A block that cannot be compressed invalidates both tags already held. Afterwards only its own tag hits, in slot 0.
- R7: A compressible block filled into a line held by a full-width block replaces it. The new block goes into the lower half, and slot 1 stays invalid.
- R8: A compressible fill whose tag matches a block held in one half overwrites that half in place. The other half's block is kept.
- R9: When both halves are valid and a compressible fill carries a new tag, it replaces the half whose block was written less recently.
- R10: `rd_resp_valid` is high exactly in the cycle after a cycle with `rd_valid` high, and low otherwise. A read issued in the same cycle as a fill returns the contents held before that fill.
- R11: `rd_way` gives the matching tag slot (0 or 1) on a hit. On a miss, `rd_hit`, `rd_way`, `rd_half_en` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Write a new block into the line this cycle |
| fill_tag | input | TAG_W | Tag of the block being filled |
| fill_data | input | WORDS*32 | Block contents, word i in bits 32i+31:32i |
| rd_valid | input | 1 | Read request this cycle |
| rd_tag | input | TAG_W | Tag of the requested block |
| rd_idx | input | clog2(WORDS) | Word index within the block |
| rd_resp_valid | output | 1 | Read response present this cycle |
| rd_hit | output | 1 | Requested tag is held in the line |
| rd_way | output | 1 | Tag slot that matched (0 or 1) |
| rd_half_en | output | 2 | Halves enabled: bit 0 lower, bit 1 upper |
| rd_data | output | 32 | Rebuilt word |

## Verification
A wrong tag-valid or mode bit shows up on the first read after the fill that set it. A block that should hit will miss, a block that should be gone will still hit, or `rd_half_en` and `rd_way` will point at the wrong half, all one cycle after the request. Damage to a stored sign or status bit shows up as a corrupted upper half-word on the next read of that word. The placement rule only shows after a sequence of fills, so the directed tests chain fills that reach each placement branch and read every resident block after each step.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // True when the upper half-word carries no information beyond one bit.
  function automatic logic upper_is_sign(word_t w);
    return (w[WORD_W-1:HALF_W] == '0) || (w[WORD_W-1:HALF_W] == '1);
  endfunction

  // Rebuild a word from its kept sign bit and low half-word.
  function automatic word_t widen(logic s, half_t lo);
    return {{HALF_W{s}}, lo};
  endfunction
endpackage

// File: rtl/scl_word_codec.sv
module scl_word_codec
  import scl_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic [WORDS*WORD_W-1:0] blk,
  output half_t                   lo   [WORDS],
  output half_t                   hi   [WORDS],
  output logic  [WORDS-1:0]       sgn,
  output logic  [WORDS-1:0]       fits,
  output logic                    all_fit
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    word_t w;
    assign w       = blk[g*WORD_W +: WORD_W];
    assign lo[g]   = w[HALF_W-1:0];
    assign hi[g]   = w[WORD_W-1:HALF_W];
    assign sgn[g]  = w[WORD_W-1];
    assign fits[g] = upper_is_sign(w);
  end

  assign all_fit = &fits;
endmodule

// File: rtl/scl_tag_match.sv
module scl_tag_match #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] tag0,
  input  logic [TAG_W-1:0] tag1,
  input  logic [1:0]       vld,
  output logic [1:0]       hit
);
  assign hit[0] = vld[0] && (tag0 == req_tag);
  assign hit[1] = vld[1] && (tag1 == req_tag);

  // R5
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit))
    else $error("both tag slots match one request");
endmodule

// File: rtl/scl_half_store.sv
module scl_half_store
  import scl_pkg::*;
#(
  parameter  int WORDS = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  half_t            wlow [WORDS],
  input  logic [WORDS-1:0] wsgn,
  input  logic [WORDS-1:0] wcmp,
  input  logic [IDX_W-1:0] ridx,
  output half_t            rlow,
  output logic             rsgn,
  output logic             rcmp
);
  half_t            mem [WORDS];
  logic [WORDS-1:0] sgn_q;
  logic [WORDS-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      sgn_q <= '0;
      cmp_q <= '0;
    end else if (we) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= wlow[i];
      sgn_q <= wsgn;
      cmp_q <= wcmp;
    end
  end

  assign rlow = mem[ridx];
  assign rsgn = sgn_q[ridx];
  assign rcmp = cmp_q[ridx];
endmodule

// File: rtl/scl_line.sv
module scl_line
  import scl_pkg::*;
#(
  parameter  int WORDS = 8,
  parameter  int TAG_W = 20,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_valid,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [WORDS*WORD_W-1:0] fill_data,
  input  logic                    rd_valid,
  input  logic [TAG_W-1:0]        rd_tag,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_resp_valid,
  output logic                    rd_hit,
  output logic                    rd_way,
  output logic [1:0]              rd_half_en,
  output logic [WORD_W-1:0]       rd_data
);
  // line state
  logic [TAG_W-1:0] tag_q [2];
  logic [1:0]       tvld_q;
  logic             full_q;   // one full-width block occupies both halves
  logic             age_q;    // index of the half written less recently

  // fill-side codec
  half_t            c_lo [WORDS];
  half_t            c_hi [WORDS];
  logic [WORDS-1:0] c_sgn;
  logic [WORDS-1:0] c_fits;
  logic             c_all_fit;

  scl_word_codec #(.WORDS(WORDS)) i_codec (
    .blk(fill_data), .lo(c_lo), .hi(c_hi), .sgn(c_sgn), .fits(c_fits), .all_fit(c_all_fit)
  );

  // named fill events
  logic fill_is_full;
  logic fill_is_half;
  logic fill_tgt;
  logic [1:0] fhit;

  assign fill_is_full = fill_valid && !c_all_fit;
  assign fill_is_half = fill_valid &&  c_all_fit;

  scl_tag_match #(.TAG_W(TAG_W)) i_fill_match (
    .clk(clk), .rst_n(rst_n), .req_tag(fill_tag),
    .tag0(tag_q[0]), .tag1(tag_q[1]), .vld(tvld_q), .hit(fhit)
  );

  always_comb begin
    if (full_q)         fill_tgt = 1'b0;
    else if (fhit[0])   fill_tgt = 1'b0;
    else if (fhit[1])   fill_tgt = 1'b1;
    else if (!tvld_q[0]) fill_tgt = 1'b0;
    else if (!tvld_q[1]) fill_tgt = 1'b1;
    else                fill_tgt = age_q;
  end

  // two half arrays
  half_t      h_rlow [2];
  logic [1:0] h_rsgn;
  logic [1:0] h_rcmp;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic             we;
    half_t            wlow [WORDS];
    logic [WORDS-1:0] wcmp;

    assign we = fill_is_full || (fill_is_half && (fill_tgt == 1'(h)));

    always_comb begin
      for (int i = 0; i < WORDS; i++)
        wlow[i] = (fill_is_full && h == 1) ? c_hi[i] : c_lo[i];
    end

    if (h == 0) begin : g_lo_status
      assign wcmp = fill_is_full ? c_fits : '1;
    end else begin : g_hi_status
      assign wcmp = fill_is_full ? '0 : '1;
    end

    scl_half_store #(.WORDS(WORDS)) i_store (
      .clk(clk), .rst_n(rst_n), .we(we), .wlow(wlow), .wsgn(c_sgn), .wcmp(wcmp),
      .ridx(rd_idx), .rlow(h_rlow[h]), .rsgn(h_rsgn[h]), .rcmp(h_rcmp[h])
    );
  end

  // tag state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q[0] <= '0;
      tag_q[1] <= '0;
      tvld_q   <= 2'b00;
      full_q   <= 1'b0;
      age_q    <= 1'b0;
    end else if (fill_is_full) begin
      tag_q[0] <= fill_tag;
      tvld_q   <= 2'b01;
      full_q   <= 1'b1;
      age_q    <= 1'b1;
    end else if (fill_is_half) begin
      tag_q[fill_tgt] <= fill_tag;
      if (full_q) tvld_q <= 2'b01;
      else        tvld_q[fill_tgt] <= 1'b1;
      full_q <= 1'b0;
      age_q  <= ~fill_tgt;
    end
  end

  // read path
  logic [1:0]  rhit;
  logic        r_hit;
  logic        r_way;
  logic [1:0]  r_en;
  word_t       r_data;

  scl_tag_match #(.TAG_W(TAG_W)) i_rd_match (
    .clk(clk), .rst_n(rst_n), .req_tag(rd_tag),
    .tag0(tag_q[0]), .tag1(tag_q[1]), .vld(tvld_q), .hit(rhit)
  );

  always_comb begin
    r_hit  = 1'b0;
    r_way  = 1'b0;
    r_en   = 2'b00;
    r_data = '0;
    if (rhit[1]) begin
      r_hit  = 1'b1;
      r_way  = 1'b1;
      r_en   = 2'b10;
      r_data = widen(h_rsgn[1], h_rlow[1]);
    end else if (rhit[0]) begin
      r_hit  = 1'b1;
      r_en   = full_q ? 2'b11 : 2'b01;
      r_data = h_rcmp[0] ? widen(h_rsgn[0], h_rlow[0]) : {h_rlow[1], h_rlow[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_hit        <= 1'b0;
      rd_way        <= 1'b0;
      rd_half_en    <= 2'b00;
      rd_data       <= '0;
    end else begin
      rd_resp_valid <= rd_valid;
      rd_hit        <= rd_valid && r_hit;
      rd_way        <= rd_valid && r_way;
      rd_half_en    <= rd_valid ? r_en : 2'b00;
      rd_data       <= rd_valid ? r_data : '0;
    end
  end

  // R10
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid) else $error("read response missing");

  // R6
  full_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_is_full |=> (tvld_q == 2'b01) && full_q) else $error("stale tag after full fill");

  // R11
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_half_en == 2'b00) && (rd_data == '0) && !rd_way)
    else $error("miss response not cleared");

  // R4
  hit_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_half_en != 2'b00)) else $error("hit with no half enabled");

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && rd_half_en != 2'b11) |->
      (rd_data[WORD_W-1:HALF_W] == '0) || (rd_data[WORD_W-1:HALF_W] == '1))
    else $error("half-line word has mixed upper bits");

  // R4
  upper_compressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rhit[1] |-> h_rcmp[1]) else $error("upper half word not marked compressed");
endmodule

// File: tb/test_scl_line.sv
module test_scl_line;
  import scl_pkg::*;

  localparam int WORDS = 8;
  localparam int TAG_W = 20;
  localparam int BLK_W = WORDS * WORD_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             fill_valid;
  logic [TAG_W-1:0] fill_tag;
  logic [BLK_W-1:0] fill_data;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [2:0]       rd_idx;
  logic             rd_resp_valid, rd_hit, rd_way;
  logic [1:0]       rd_half_en;
  logic [31:0]      rd_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scl_line #(.WORDS(WORDS), .TAG_W(TAG_W)) i_scl_line (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_tag(fill_tag),
    .fill_data(fill_data), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_idx(rd_idx),
    .rd_resp_valid(rd_resp_valid), .rd_hit(rd_hit), .rd_way(rd_way),
    .rd_half_en(rd_half_en), .rd_data(rd_data)
  );

  // word value, expected to shrink
  localparam logic [32:0] VEC [9] = '{
    {1'b1, 32'h0000_1234}, {1'b1, 32'hFFFF_8001}, {1'b1, 32'h0000_8000},
    {1'b1, 32'hFFFF_0000}, {1'b1, 32'h0000_0000}, {1'b0, 32'h0001_0000},
    {1'b0, 32'h7FFF_FFFF}, {1'b0, 32'h8000_0000}, {1'b0, 32'hFFFE_FFFF}
  };

  function automatic logic [BLK_W-1:0] rep(logic [31:0] w);
    return {WORDS{w}};
  endfunction

  function automatic logic [BLK_W-1:0] seq(logic [31:0] base);
    logic [BLK_W-1:0] b;
    for (int i = 0; i < WORDS; i++) b[i*32 +: 32] = base + 32'(i);
    return b;
  endfunction

  task automatic chk(string req, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (valid,hit,way,en,data)", req, act, exp);
    end
  endtask

  task automatic do_fill(logic [TAG_W-1:0] t, logic [BLK_W-1:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_read(string req, logic [TAG_W-1:0] t, int idx,
                         logic eh, logic ew, logic [1:0] een, logic [31:0] ed);
    @(negedge clk);
    rd_valid = 1'b1; rd_tag = t; rd_idx = 3'(idx);
    @(negedge clk);
    rd_valid = 1'b0;
    chk(req, {rd_resp_valid, rd_hit, rd_way, rd_half_en, rd_data}, {1'b1, eh, ew, een, ed});
  endtask

  task automatic expect_miss(string req, logic [TAG_W-1:0] t);
    do_read(req, t, 0, 1'b0, 1'b0, 2'b00, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mix [WORDS];
    logic [BLK_W-1:0] mblk;
    rst_n = 1'b0; fill_valid = 1'b0; fill_tag = '0; fill_data = '0;
    rd_valid = 1'b0; rd_tag = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_miss("R1 reset miss", 20'h5);
    @(negedge clk);
    chk("R10 idle no response", {rd_resp_valid, 36'h0}, 37'h0);

    // R2/R3/R4 table walk: one word repeated, same tag each time
    foreach (VEC[i]) begin
      do_fill(20'h100, rep(VEC[i][31:0]));
      do_read(VEC[i][32] ? "R2 shrinkable word" : "R3 full-width word",
              20'h100, i % WORDS, 1'b1, 1'b0,
              VEC[i][32] ? 2'b01 : 2'b11, VEC[i][31:0]);
    end

    // R3 mixed block
    mix = '{32'h0000_1234, 32'h1234_5678, 32'hFFFF_ABCD, 32'h0000_0000,
            32'hDEAD_BEEF, 32'hFFFF_0001, 32'h0000_8000, 32'h8000_0001};
    for (int i = 0; i < WORDS; i++) mblk[i*32 +: 32] = mix[i];
    do_fill(20'hA, mblk);
    for (int i = 0; i < WORDS; i++)
      do_read("R3 mixed word", 20'hA, i, 1'b1, 1'b0, 2'b11, mix[i]);

    // R7 compressible fill over full line
    do_fill(20'hB, seq(32'hFFFF_FFFC));
    expect_miss("R7 full block replaced", 20'hA);
    do_read("R4 lower half", 20'hB, 2, 1'b1, 1'b0, 2'b01, 32'hFFFF_FFFE);

    // R5 second block into free half
    do_fill(20'hC, seq(32'h0000_0100));
    do_read("R5 upper half block", 20'hC, 5, 1'b1, 1'b1, 2'b10, 32'h0000_0105);
    do_read("R5 lower block kept", 20'hB, 7, 1'b1, 1'b0, 2'b01, 32'h0000_0003);

    // R8 in-place overwrite
    do_fill(20'hB, seq(32'h0000_7000));
    do_read("R8 overwritten half", 20'hB, 1, 1'b1, 1'b0, 2'b01, 32'h0000_7001);
    do_read("R8 other half kept", 20'hC, 0, 1'b1, 1'b1, 2'b10, 32'h0000_0100);

    // R9 older half replaced (C older than refilled B)
    do_fill(20'hD, seq(32'hFFFF_F000));
    expect_miss("R9 older block evicted", 20'hC);
    do_read("R9 new block upper", 20'hD, 3, 1'b1, 1'b1, 2'b10, 32'hFFFF_F003);
    do_read("R9 newer block kept", 20'hB, 4, 1'b1, 1'b0, 2'b01, 32'h0000_7004);
    do_fill(20'hE, seq(32'h0000_0040));
    expect_miss("R9 second eviction", 20'hB);
    do_read("R9 new block lower", 20'hE, 6, 1'b1, 1'b0, 2'b01, 32'h0000_0046);
    do_read("R11 way report", 20'hD, 0, 1'b1, 1'b1, 2'b10, 32'hFFFF_F000);

    // R6 full-width fill drops both halves
    do_fill(20'hF, seq(32'h1234_0000));
    expect_miss("R6 lower tag dropped", 20'hE);
    expect_miss("R6 upper tag dropped", 20'hD);
    do_read("R6 full block", 20'hF, 0, 1'b1, 1'b0, 2'b11, 32'h1234_0000);

    // R10 read alongside fill sees old contents
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = 20'h9; fill_data = rep(32'h0000_00AA);
    rd_valid = 1'b1; rd_tag = 20'hF; rd_idx = 3'd2;
    @(negedge clk);
    fill_valid = 1'b0; rd_valid = 1'b0;
    chk("R10 pre-fill contents", {rd_resp_valid, rd_hit, rd_way, rd_half_en, rd_data},
        {1'b1, 1'b1, 1'b0, 2'b11, 32'h1234_0002});
    expect_miss("R10 fill applied", 20'hF);
    do_read("R10 new block", 20'h9, 7, 1'b1, 1'b0, 2'b01, 32'h0000_00AA);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule